// File: doc/BRIEF.md
# Configuration Request TLP Engine

This block converts one register-style configuration access from a host into a single-DWORD configuration request packet and waits for its completion. The host presents a bus, device, function, register offset, access size, direction and write data. The engine sends four header DWORDs on a transmit stream, plus one data DWORD for a write. It then waits for one completion beat that carries a descriptor and a data DWORD. It returns a status code and read data that has already been shifted into the low lanes and masked to the access size.

Before it sends anything, the engine decides whether the request should go out at all. Bus numbers above a threshold become Type 1 requests, and those require the link to be up. On the threshold bus itself, only a short list of device slots is forwarded. Any request that is not forwarded completes at once as device-not-found. Stalls on the transmit side and missing completions are bounded by cycle-count limits. Every failure returns all-ones read data. Only one access is in flight at a time.

Top module: `cfg_tlp_engine`

## Requirements
- R1: After reset, req_ready is 1, tx_valid is 0 and resp_valid is 0.
- R2: Header beat 0 is 0x04000001 for a read and 0x44000001 for a write, with the request type (1 for Type 1, 0 for Type 0) ORed in at bit 24.
- R3: Header beat 1 is 0x00002000 ORed with the 3-bit tag at bits 10:8 and the byte enables in bits 3:0. The access size is encoded as 0 for a byte, 1 for a halfword, and 2 or 3 for a word. The byte enables are 1<<(offset mod 4) for a byte, 0x3<<(2*((offset>>1) mod 2)) for a halfword, and 0xF for a word.
- R4: Header beat 2 holds the bus in bits 31:24, the device in 23:19, the function in 18:16 and the offset in 15:0 with bits 1:0 cleared. Header beat 3 is zero.
- R5: A read sends exactly 4 beats. A write sends 5 beats, and the fifth is the write data masked to the access size and shifted left by 8*(offset mod 4), keeping 32 bits.
- R6: For a successful read, resp_rdata is the completion data shifted right by 8*(offset mod 4) for a byte access, or by 8*(offset & 2) for a halfword access, and then masked to the size. A word access returns the data unchanged. A successful write returns 0.
- R7: The tag starts at 0 after reset. It advances by one, modulo 8, after every access that sent a packet, whether that access passed or failed. A rejected access does not advance it.
- R8: Bus numbers above 128 use Type 1; all other bus numbers use Type 0.
- R9: On bus 128, only device slots 0 and 8 are forwarded. Any other slot sends nothing and gives resp_status 1 (device-not-found) with all-ones data, and resp_valid rises in the cycle right after the request is accepted.
- R10: A Type 1 access while link_up is 0 sends nothing and returns status 1 with all-ones data.
- R11: If bits 15:13 of the completion descriptor are nonzero, resp_status is 0 (success) and resp_rdata is all ones, for both reads and writes.
- R12: If tx_ready stays low for TX_LIMIT consecutive cycles while a beat is offered, or no completion arrives within RX_LIMIT cycles after the last beat, the access ends with status 2 (timeout) and all-ones data.
- R13: req_ready is 0 from the cycle after a request is accepted until the cycle after its resp_valid pulse. resp_valid lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host presents an access |
| req_ready | output | 1 | Engine idle; access is taken when both are high |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device slot |
| req_func | input | 3 | Target function |
| req_offset | input | 12 | Register byte offset |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_wdata | input | 32 | Write data, right-aligned |
| link_up | input | 1 | Link is up; required for Type 1 |
| tx_valid | output | 1 | Transmit beat offered |
| tx_ready | input | 1 | Transmit beat taken |
| tx_data | output | 32 | Header or data DWORD |
| tx_last | output | 1 | Final beat of the packet |
| rx_valid | input | 1 | Completion beat present |
| rx_desc | input | 32 | Completion descriptor, status in bits 15:13 |
| rx_data | input | 32 | Completion data DWORD |
| resp_valid | output | 1 | One-cycle result pulse |
| resp_status | output | 2 | 0 success, 1 device-not-found, 2 timeout |
| resp_rdata | output | 32 | Aligned read data or all ones |

## Verification
The assertions check the following on every cycle: the byte-enable popcount against the latched size, stability of an offered beat that is stalled, the one-step tag advance after each sent access, all-ones data on every timeout, a silent and immediate answer to a rejected request, and the bounded watchdog count. Only the bench scenarios can show the exact header words, the lane shifts for each offset and size (including the halfword-at-odd-offset case), Type 0/Type 1 selection, the slot filter on bus 128, completion-error substitution, and the tag wrap over many accesses.

// File: rtl/cfg_tlp_pkg.sv
package cfg_tlp_pkg;

   localparam int BUS_W = 8;
   localparam int DEV_W = 5;
   localparam int FN_W  = 3;
   localparam int DW    = 32;

   localparam logic [31:0] HDR0_READ  = 32'h0400_0000;
   localparam logic [31:0] HDR0_WRITE = 32'h4400_0000;
   localparam logic [31:0] HDR0_LEN1  = 32'h0000_0001;

   typedef enum logic [1:0] {
      ST_OK        = 2'd0,
      ST_NOT_FOUND = 2'd1,
      ST_TIMEOUT   = 2'd2
   } cfg_status_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } cfg_size_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SEND = 2'd1,
      PH_WAIT = 2'd2,
      PH_RESP = 2'd3
   } cfg_phase_e;

endpackage

// File: rtl/cfg_tlp_lanes.sv
module cfg_tlp_lanes
   import cfg_tlp_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic [1:0]        size,
   input  logic [1:0]        off_lo,
   input  logic [WORD_W-1:0] wdata,
   input  logic [WORD_W-1:0] cpl_data,
   output logic [3:0]        be,
   output logic [WORD_W-1:0] wlane,
   output logic [WORD_W-1:0] rlane
);

   localparam int NBYTES = WORD_W / 8;

   generate
      if (WORD_W != 32) begin : g_bad_width
         initial $error("cfg_tlp_lanes: WORD_W must be 32");
      end
   endgenerate

   logic [WORD_W-1:0] mask;
   logic [4:0]        wshift;
   logic [4:0]        rshift;
   logic [NBYTES-1:0] keep;

   always_comb begin
      case (size)
         SZ_BYTE: begin
            keep   = 4'b0001;
            be     = 4'b0001 << off_lo;
            wshift = {off_lo, 3'b000};
            rshift = {off_lo, 3'b000};
         end
         SZ_HALF: begin
            keep   = 4'b0011;
            be     = 4'b0011 << {off_lo[1], 1'b0};
            wshift = {off_lo, 3'b000};
            rshift = {off_lo[1], 4'b0000};
         end
         default: begin
            keep   = 4'b1111;
            be     = 4'b1111;
            wshift = 5'd0;
            rshift = 5'd0;
         end
      endcase
   end

   genvar gi;
   generate
      for (gi = 0; gi < NBYTES; gi++) begin : g_mask
         assign mask[gi*8 +: 8] = {8{keep[gi]}};
      end
   endgenerate

   assign wlane = (wdata & mask) << wshift;
   assign rlane = (cpl_data >> rshift) & mask;

endmodule

// File: rtl/cfg_tlp_route.sv
module cfg_tlp_route
   import cfg_tlp_pkg::*;
#(
   parameter int                   FILTER_BUS = 128,
   parameter int                   NUM_FWD    = 2,
   parameter logic [NUM_FWD*5-1:0] FWD_LIST   = {5'd8, 5'd0}
) (
   input  logic [BUS_W-1:0] bus,
   input  logic [DEV_W-1:0] dev,
   input  logic             link_up,
   output logic             type1,
   output logic             reject
);

   generate
      if (NUM_FWD < 1) begin : g_bad_fwd
         initial $error("cfg_tlp_route: NUM_FWD must be at least 1");
      end
      if (FILTER_BUS < 0 || FILTER_BUS > 255) begin : g_bad_bus
         initial $error("cfg_tlp_route: FILTER_BUS out of range");
      end
   endgenerate

   localparam logic [BUS_W-1:0] FBUS = BUS_W'(FILTER_BUS);

   logic [NUM_FWD-1:0] hit;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_FWD; gi++) begin : g_slot
         assign hit[gi] = (dev == FWD_LIST[gi*DEV_W +: DEV_W]);
      end
   endgenerate

   logic filtered;
   assign type1    = (bus > FBUS);
   assign filtered = (bus == FBUS) && !(|hit);
   assign reject   = filtered || (type1 && !link_up);

endmodule

// File: rtl/cfg_tlp_wdog.sv
module cfg_tlp_wdog #(
   parameter int TX_LIMIT = 32,
   parameter int RX_LIMIT = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   input  logic sel_rx,
   output logic expired
);

   generate
      if (TX_LIMIT < 2 || RX_LIMIT < 2) begin : g_bad_limit
         initial $error("cfg_tlp_wdog: limits must be at least 2");
      end
   endgenerate

   localparam int MAXL  = (TX_LIMIT > RX_LIMIT) ? TX_LIMIT : RX_LIMIT;
   localparam int CNT_W = $clog2(MAXL + 1);
   localparam logic [CNT_W-1:0] TX_END = CNT_W'(TX_LIMIT - 1);
   localparam logic [CNT_W-1:0] RX_END = CNT_W'(RX_LIMIT - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] end_val;

   assign end_val = sel_rx ? RX_END : TX_END;
   assign expired = run && !clear && (cnt_q == end_val);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_WDOG_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> cnt_q <= end_val) else $error("watchdog count past limit"); // R12

endmodule

// File: rtl/cfg_tlp_engine.sv
module cfg_tlp_engine
   import cfg_tlp_pkg::*;
#(
   parameter int                   OFF_W      = 12,
   parameter int                   TAG_W      = 3,
   parameter logic [31:0]          REQ_CONST  = 32'h0000_2000,
   parameter int                   TX_LIMIT   = 32,
   parameter int                   RX_LIMIT   = 200,
   parameter int                   FILTER_BUS = 128,
   parameter int                   NUM_FWD    = 2,
   parameter logic [NUM_FWD*5-1:0] FWD_LIST   = {5'd8, 5'd0}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_write,
   input  logic [7:0]       req_bus,
   input  logic [4:0]       req_dev,
   input  logic [2:0]       req_func,
   input  logic [OFF_W-1:0] req_offset,
   input  logic [1:0]       req_size,
   input  logic [31:0]      req_wdata,
   input  logic             link_up,
   output logic             tx_valid,
   input  logic             tx_ready,
   output logic [31:0]      tx_data,
   output logic             tx_last,
   input  logic             rx_valid,
   input  logic [31:0]      rx_desc,
   input  logic [31:0]      rx_data,
   output logic             resp_valid,
   output logic [1:0]       resp_status,
   output logic [31:0]      resp_rdata
);

   generate
      if (TAG_W < 1 || TAG_W > 8) begin : g_bad_tag
         initial $error("cfg_tlp_engine: TAG_W must be 1..8");
      end
      if (OFF_W < 2 || OFF_W > 16) begin : g_bad_off
         initial $error("cfg_tlp_engine: OFF_W must be 2..16");
      end
   endgenerate

   cfg_phase_e       phase_q;
   logic             wr_q;
   logic [7:0]       bus_q;
   logic [4:0]       dev_q;
   logic [2:0]       fn_q;
   logic [OFF_W-1:0] off_q;
   logic [1:0]       size_q;
   logic [31:0]      wdata_q;
   logic             type1_q;
   logic             sent_q;
   logic [2:0]       beat_q;
   logic [TAG_W-1:0] tag_q;
   logic [1:0]       status_q;
   logic [31:0]      rdata_q;

   // request routing on the live request fields
   logic rt_type1;
   logic rt_reject;

   cfg_tlp_route #(
      .FILTER_BUS (FILTER_BUS),
      .NUM_FWD    (NUM_FWD),
      .FWD_LIST   (FWD_LIST)
   ) u_route (
      .bus     (req_bus),
      .dev     (req_dev),
      .link_up (link_up),
      .type1   (rt_type1),
      .reject  (rt_reject)
   );

   // lane alignment on the latched fields
   logic [3:0]  be;
   logic [31:0] wlane;
   logic [31:0] rlane;

   cfg_tlp_lanes #(
      .WORD_W (DW)
   ) u_lanes (
      .size     (size_q),
      .off_lo   (off_q[1:0]),
      .wdata    (wdata_q),
      .cpl_data (rx_data),
      .be       (be),
      .wlane    (wlane),
      .rlane    (rlane)
   );

   // transfer watchdog
   logic wd_clear;
   logic wd_run;
   logic wd_expired;

   assign wd_clear = (phase_q == PH_IDLE) || (tx_valid && tx_ready);
   assign wd_run   = (phase_q == PH_SEND) || (phase_q == PH_WAIT);

   cfg_tlp_wdog #(
      .TX_LIMIT (TX_LIMIT),
      .RX_LIMIT (RX_LIMIT)
   ) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (wd_clear),
      .run     (wd_run),
      .sel_rx  (phase_q == PH_WAIT),
      .expired (wd_expired)
   );

   // header words
   logic [31:0] hdr0;
   logic [31:0] hdr1;
   logic [31:0] hdr2;
   logic [15:0] off16;
   logic [2:0]  last_beat;

   assign off16     = 16'(off_q) & 16'hFFFC;
   assign hdr0      = (wr_q ? HDR0_WRITE : HDR0_READ) | HDR0_LEN1 | (32'(type1_q) << 24);
   assign hdr1      = REQ_CONST | (32'(tag_q) << 8) | 32'(be);
   assign hdr2      = {bus_q, dev_q, fn_q, off16};
   assign last_beat = wr_q ? 3'd4 : 3'd3;

   always_comb begin
      case (beat_q)
         3'd0:    tx_data = hdr0;
         3'd1:    tx_data = hdr1;
         3'd2:    tx_data = hdr2;
         3'd3:    tx_data = 32'h0;
         default: tx_data = wlane;
      endcase
   end

   assign req_ready   = (phase_q == PH_IDLE);
   assign tx_valid    = (phase_q == PH_SEND);
   assign tx_last     = tx_valid && (beat_q == last_beat);
   assign resp_valid  = (phase_q == PH_RESP);
   assign resp_status = status_q;
   assign resp_rdata  = rdata_q;

   logic cpl_err;
   assign cpl_err = (rx_desc[15:13] != 3'b000);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         wr_q     <= 1'b0;
         bus_q    <= '0;
         dev_q    <= '0;
         fn_q     <= '0;
         off_q    <= '0;
         size_q   <= '0;
         wdata_q  <= '0;
         type1_q  <= 1'b0;
         sent_q   <= 1'b0;
         beat_q   <= '0;
         tag_q    <= '0;
         status_q <= ST_OK;
         rdata_q  <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               if (req_valid) begin
                  wr_q    <= req_write;
                  bus_q   <= req_bus;
                  dev_q   <= req_dev;
                  fn_q    <= req_func;
                  off_q   <= req_offset;
                  size_q  <= req_size;
                  wdata_q <= req_wdata;
                  type1_q <= rt_type1;
                  beat_q  <= '0;
                  if (rt_reject) begin
                     sent_q   <= 1'b0;
                     status_q <= ST_NOT_FOUND;
                     rdata_q  <= '1;
                     phase_q  <= PH_RESP;
                  end else begin
                     sent_q  <= 1'b1;
                     phase_q <= PH_SEND;
                  end
               end
            end
            PH_SEND: begin
               if (tx_ready) begin
                  beat_q <= beat_q + 1'b1;
                  if (beat_q == last_beat) begin
                     phase_q <= PH_WAIT;
                  end
               end else if (wd_expired) begin
                  status_q <= ST_TIMEOUT;
                  rdata_q  <= '1;
                  phase_q  <= PH_RESP;
               end
            end
            PH_WAIT: begin
               if (rx_valid) begin
                  status_q <= ST_OK;
                  if (cpl_err) begin
                     rdata_q <= '1;
                  end else if (wr_q) begin
                     rdata_q <= '0;
                  end else begin
                     rdata_q <= rlane;
                  end
                  phase_q <= PH_RESP;
               end else if (wd_expired) begin
                  status_q <= ST_TIMEOUT;
                  rdata_q  <= '1;
                  phase_q  <= PH_RESP;
               end
            end
            default: begin
               if (sent_q) begin
                  tag_q <= tag_q + 1'b1;
               end
               phase_q <= PH_IDLE;
            end
         endcase
      end
   end

   AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && sent_q) |=> (tag_q == $past(tag_q) + 1'b1)) else $error("tag step"); // R7

   AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !sent_q) |=> $stable(tag_q)) else $error("tag moved on reject"); // R7

   AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && beat_q == 3'd1) |->
         ($countones(tx_data[3:0]) == ((size_q == SZ_BYTE) ? 1 : (size_q == SZ_HALF) ? 2 : 4)))
      else $error("byte enable count"); // R3

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !wd_expired) |=> (tx_valid && $stable(tx_data)))
      else $error("offered beat changed"); // R5

   AST_TIMEOUT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_status == ST_TIMEOUT) |-> (resp_rdata == 32'hFFFF_FFFF))
      else $error("timeout data"); // R12

   AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && rt_reject) |=> (resp_valid && !tx_valid && resp_status == ST_NOT_FOUND))
      else $error("reject not immediate"); // R9

   AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> (!resp_valid && req_ready)) else $error("response pulse"); // R13

endmodule

// File: tb/sim_cfg_tlp_engine.sv
`timescale 1ns/1ps
module sim_cfg_tlp_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [7:0]  req_bus = '0;
   logic [4:0]  req_dev = '0;
   logic [2:0]  req_func = '0;
   logic [11:0] req_offset = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        link_up = 1'b1;
   logic        tx_valid;
   logic        tx_ready = 1'b1;
   logic [31:0] tx_data;
   logic        tx_last;
   logic        rx_valid = 1'b0;
   logic [31:0] rx_desc = '0;
   logic [31:0] rx_data = '0;
   logic        resp_valid;
   logic [1:0]  resp_status;
   logic [31:0] resp_rdata;

   int   n_chk = 0;
   int   n_bad = 0;
   logic [2:0] exp_tag = 3'd0;

   always #10 clk = ~clk;

   cfg_tlp_engine u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
      .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
      .link_up(link_up),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
      .rx_valid(rx_valid), .rx_desc(rx_desc), .rx_data(rx_data),
      .resp_valid(resp_valid), .resp_status(resp_status), .resp_rdata(resp_rdata)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] f_be(input logic [1:0] sz, input logic [11:0] off);
      case (sz)
         2'd0:    f_be = 4'b0001 << off[1:0];
         2'd1:    f_be = off[1] ? 4'b1100 : 4'b0011;
         default: f_be = 4'b1111;
      endcase
   endfunction

   function automatic logic [31:0] f_mask(input logic [1:0] sz);
      case (sz)
         2'd0:    f_mask = 32'h0000_00FF;
         2'd1:    f_mask = 32'h0000_FFFF;
         default: f_mask = 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic logic [31:0] f_wlane(input logic [1:0] sz, input logic [11:0] off,
                                           input logic [31:0] wd);
      if (sz >= 2'd2) f_wlane = wd;
      else            f_wlane = (wd & f_mask(sz)) << (8 * off[1:0]);
   endfunction

   function automatic logic [31:0] f_rlane(input logic [1:0] sz, input logic [11:0] off,
                                           input logic [31:0] d);
      case (sz)
         2'd0:    f_rlane = (d >> (8 * off[1:0])) & 32'hFF;
         2'd1:    f_rlane = (d >> (8 * {off[1], 1'b0})) & 32'hFFFF;
         default: f_rlane = d;
      endcase
   endfunction

   function automatic logic f_type1(input logic [7:0] bus);
      f_type1 = (bus > 8'd128);
   endfunction

   function automatic logic f_reject(input logic [7:0] bus, input logic [4:0] dev, input logic lk);
      f_reject = ((bus == 8'd128) && (dev != 5'd0) && (dev != 5'd8)) || (f_type1(bus) && !lk);
   endfunction

   // mode 0: normal, 1: transmit stalled, 2: no completion
   task automatic run_access(input logic wr, input logic [7:0] bus, input logic [4:0] dev,
                             input logic [2:0] fn, input logic [11:0] off, input logic [1:0] sz,
                             input logic [31:0] wd, input logic lk, input int mode,
                             input logic [31:0] desc, input logic [31:0] cdat);
      logic [31:0] beats [0:7];
      int nb = 0;
      int cyc = 0;
      int delay = 0;
      int busy_bad = 0;
      logic rej;
      logic [31:0] exp_data;
      int exp_nb;
      rej    = f_reject(bus, dev, lk);
      exp_nb = wr ? 5 : 4;
      for (int i = 0; i < 8; i++) beats[i] = '0;
      @(negedge clk);
      chk({31'd0, req_ready}, 32'd1, "R13 ready before request");
      link_up    = lk;
      tx_ready   = (mode == 1) ? 1'b0 : 1'b1;
      req_write  = wr;
      req_bus    = bus;
      req_dev    = dev;
      req_func   = fn;
      req_offset = off;
      req_size   = sz;
      req_wdata  = wd;
      req_valid  = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (cyc < 1000) begin
         if (resp_valid) break;
         if (req_ready) busy_bad++;
         if (rx_valid) rx_valid = 1'b0;
         if (tx_valid && tx_ready) begin
            if (nb < 8) beats[nb] = tx_data;
            nb++;
            if (nb == exp_nb && mode == 0) delay = 3;
         end
         if (delay > 0) begin
            delay--;
            if (delay == 0) begin
               rx_valid = 1'b1;
               rx_desc  = desc;
               rx_data  = cdat;
            end
         end
         cyc++;
         @(negedge clk);
      end
      rx_valid = 1'b0;
      chk({31'd0, resp_valid}, 32'd1, "R13 response seen");
      chk(busy_bad, 0, "R13 ready low while busy");
      if (rej) begin
         chk(nb, 0, f_type1(bus) ? "R10 no packet on link down" : "R9 no packet for filtered slot");
         chk({30'd0, resp_status}, 32'd1, f_type1(bus) ? "R10 status" : "R9 status");
         chk(resp_rdata, 32'hFFFF_FFFF, f_type1(bus) ? "R10 data" : "R9 data");
         if (!f_type1(bus)) chk(cyc, 0, "R9 immediate answer");
      end else begin
         if (mode != 1) begin
            chk(nb, exp_nb, "R5 beat count");
            chk(beats[0], (wr ? 32'h4400_0001 : 32'h0400_0001) | (32'(f_type1(bus)) << 24),
                "R2 R8 header beat 0");
            chk(beats[1], 32'h0000_2000 | (32'(exp_tag) << 8) | 32'(f_be(sz, off)),
                "R3 R7 header beat 1");
            chk(beats[2], {bus, dev, fn, 4'd0, off[11:2], 2'b00}, "R4 header beat 2");
            chk(beats[3], 32'h0, "R4 header beat 3");
            if (wr) chk(beats[4], f_wlane(sz, off, wd), "R5 write data lane");
         end
         if (mode != 0) begin
            chk({30'd0, resp_status}, 32'd2, "R12 timeout status");
            chk(resp_rdata, 32'hFFFF_FFFF, "R12 timeout data");
         end else begin
            chk({30'd0, resp_status}, 32'd0, "R6 R11 status ok");
            if (desc[15:13] != 3'd0)  exp_data = 32'hFFFF_FFFF;
            else if (wr)              exp_data = 32'h0;
            else                      exp_data = f_rlane(sz, off, cdat);
            chk(resp_rdata, exp_data, (desc[15:13] != 3'd0) ? "R11 error data" : "R6 read data");
         end
         exp_tag = exp_tag + 3'd1;
      end
      tx_ready = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7319));
      repeat (3) @(negedge clk);
      chk({31'd0, req_ready}, 32'd1, "R1 ready in reset");
      chk({31'd0, tx_valid}, 32'd0, "R1 tx idle in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk({31'd0, req_ready}, 32'd1, "R1 ready after reset");
      chk({31'd0, tx_valid}, 32'd0, "R1 tx idle after reset");
      chk({31'd0, resp_valid}, 32'd0, "R1 no response after reset");

      // R2 R3 R4 R6: word, byte and halfword reads
      run_access(1'b0, 8'd0, 5'd1, 3'd2, 12'h010, 2'd2, 32'h0, 1'b1, 0, 32'h0, 32'h1122_3344);
      run_access(1'b0, 8'd0, 5'd1, 3'd0, 12'h013, 2'd0, 32'h0, 1'b1, 0, 32'h0, 32'hAABB_CCDD);
      run_access(1'b0, 8'd3, 5'd2, 3'd1, 12'h016, 2'd1, 32'h0, 1'b1, 0, 32'h0, 32'hAABB_CCDD);
      run_access(1'b0, 8'd3, 5'd2, 3'd1, 12'h015, 2'd1, 32'h0, 1'b1, 0, 32'h0, 32'hAABB_CCDD);
      run_access(1'b0, 8'd3, 5'd2, 3'd1, 12'hFFF, 2'd3, 32'h0, 1'b1, 0, 32'h0, 32'h0BAD_F00D);
      // R5: write lanes, including halfword at odd offset
      run_access(1'b1, 8'd0, 5'd4, 3'd0, 12'h015, 2'd1, 32'h1234_ABCD, 1'b1, 0, 32'h0, 32'h0);
      run_access(1'b1, 8'd0, 5'd4, 3'd0, 12'h02E, 2'd0, 32'hFFFF_FF5A, 1'b1, 0, 32'h0, 32'h0);
      run_access(1'b1, 8'd7, 5'd4, 3'd7, 12'h100, 2'd2, 32'hCAFE_0001, 1'b1, 0, 32'h0, 32'h0);
      // R8 R10: type 1 with link up and down
      run_access(1'b0, 8'd129, 5'd0, 3'd0, 12'h000, 2'd2, 32'h0, 1'b1, 0, 32'h0, 32'h8086_1234);
      run_access(1'b0, 8'd129, 5'd0, 3'd0, 12'h000, 2'd2, 32'h0, 1'b0, 0, 32'h0, 32'h0);
      run_access(1'b1, 8'd255, 5'd31, 3'd7, 12'h004, 2'd2, 32'h1, 1'b0, 0, 32'h0, 32'h0);
      run_access(1'b0, 8'd128, 5'd0, 3'd0, 12'h000, 2'd2, 32'h0, 1'b0, 0, 32'h0, 32'h5555_AAAA);
      // R9: slot filter on bus 128
      run_access(1'b0, 8'd128, 5'd8, 3'd1, 12'h008, 2'd2, 32'h0, 1'b1, 0, 32'h0, 32'h0102_0304);
      run_access(1'b0, 8'd128, 5'd3, 3'd0, 12'h000, 2'd2, 32'h0, 1'b1, 0, 32'h0, 32'h0);
      run_access(1'b1, 8'd128, 5'd9, 3'd0, 12'h000, 2'd2, 32'h0, 1'b1, 0, 32'h0, 32'h0);
      // R11: completion error
      run_access(1'b0, 8'd1, 5'd0, 3'd0, 12'h000, 2'd2, 32'h0, 1'b1, 0, 32'h0000_4000, 32'h1234_5678);
      run_access(1'b1, 8'd1, 5'd0, 3'd0, 12'h000, 2'd2, 32'h9, 1'b1, 0, 32'h0000_E000, 32'h0);
      // R12: transmit stall and missing completion
      run_access(1'b0, 8'd2, 5'd1, 3'd0, 12'h040, 2'd2, 32'h0, 1'b1, 1, 32'h0, 32'h0);
      run_access(1'b1, 8'd2, 5'd1, 3'd0, 12'h040, 2'd0, 32'h77, 1'b1, 2, 32'h0, 32'h0);
      run_access(1'b0, 8'd2, 5'd1, 3'd0, 12'h044, 2'd2, 32'h0, 1'b1, 0, 32'h0, 32'hDEAD_BEEF);

      // R7 and mixed patterns: random accesses, tag wraps several times
      for (int k = 0; k < 60; k++) begin
         logic [7:0]  b;
         logic [4:0]  d;
         logic [31:0] ds;
         int pick;
         pick = $urandom_range(0, 3);
         if (pick == 0)      b = 8'd0;
         else if (pick == 1) b = 8'd128;
         else if (pick == 2) b = 8'(129 + $urandom_range(0, 126));
         else                b = 8'($urandom_range(1, 127));
         d = 5'($urandom_range(0, 31));
         if (b == 8'd128 && $urandom_range(0, 1) == 0) d = ($urandom_range(0, 1) == 0) ? 5'd0 : 5'd8;
         ds = ($urandom_range(0, 3) == 0) ? (32'($urandom_range(1, 7)) << 13) : 32'h0;
         run_access(1'($urandom_range(0, 1)), b, d, 3'($urandom_range(0, 7)),
                    12'($urandom_range(0, 4095)), 2'($urandom_range(0, 3)), $urandom(),
                    ($urandom_range(0, 4) != 0), 0, ds, $urandom());
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule